// File: doc/BRIEF.md
# Inter-processor interrupt destination resolver

This block sits between the cores of a multi-core cluster and turns one interrupt command from a source core into a set of receiving cores. A command has a vector, a delivery mode, a physical/logical destination-mode bit, a shorthand and an 8-bit destination. The block resolves the command against every core's logical ID and destination-format setting. It returns a per-core accept mask and an error flag.

Fixed and lowest-priority commands are both delivered as fixed interrupts. Commands for modes that are not supported return an error.

The block also holds a start-up state for each core. An initialise command arms a core. A later start-up command releases it and produces a real-mode start address built from the vector.

Commands arrive as single-cycle strobes on `cmd_valid`. There is no ready signal: a command may be sent on every cycle, and the block never applies back-pressure. All results are registered. They appear for exactly one cycle, one cycle after the strobe, and the consumer must take them in that cycle.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset every core is in the initial start-up state (`core_waiting` and `core_running` all 0). All result outputs are 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `cmd_valid`=1 and 0 otherwise. When `res_valid` is 0, `accept_mask`, `err_flag`, `cmd_ignored` and `start_pulse` are 0.
- R3: With no shorthand (`cmd_short`=0) and logical mode (`cmd_logical`=1), destination 0xFF selects every core, whatever its format setting.
- R4: Flat logical matching (core format 4'h0): a core is selected when `cmd_dest & ldr` is non-zero.
- R5: Cluster logical matching (core format 4'hF): a core is selected when `cmd_dest[7:4]` equals `ldr[7:4]` and `cmd_dest[3:0] & ldr[3:0]` is non-zero.
- R6: In logical mode with a destination other than 0xFF, a core format other than 4'h0 or 4'hF on any core sets `err_flag`.
- R7: Shorthand 1 selects only core `cmd_src`. Shorthand 2 selects all cores. Shorthand 3 selects all cores except `cmd_src`. For shorthands 2 and 3, `cmd_logical` has no effect.
- R8: In physical mode (`cmd_logical`=0) with shorthand 0, `cmd_dest` is a core index. An index at or above the core count sets `err_flag`.
- R9: Shorthand 1 together with `cmd_logical`=1 sets `err_flag`.
- R10: Delivery modes 2, 3, 4 and 7 set `err_flag`. Modes 0 and 1 deliver as fixed, mode 5 is initialise and mode 6 is start-up.
- R11: An initialise command (mode 5) moves each selected core that is in the initial state to the waiting state (`core_waiting`=1). A selected core in any other state keeps its state and has its `cmd_ignored` bit set.
- R12: A start-up command (mode 6) moves each selected core that is waiting to running (`core_running`=1) and sets its `start_pulse` bit. `start_sel`={vector,8'h00}, `start_base`={vector,12'h000}, `start_limit`=16'hFFFF and `start_ip`=0 while any pulse bit is 1, and all are 0 otherwise. A selected core that is not waiting is unchanged and has its `cmd_ignored` bit set.
- R13: When `err_flag` is 1, `accept_mask`, `cmd_ignored` and `start_pulse` are 0 and no core's start-up state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_src | input | SRC_W | Index of the sending core |
| cmd_vector | input | 8 | Interrupt vector / start page |
| cmd_dmode | input | 3 | Delivery mode |
| cmd_logical | input | 1 | 1 = logical destination, 0 = physical |
| cmd_short | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all but self |
| cmd_dest | input | 8 | Destination field |
| core_ldr | input | 8*NUM_CORES | Logical ID per core, core i at bits [8i+7:8i] |
| core_dfr | input | 4*NUM_CORES | Format per core, core i at bits [4i+3:4i] |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| accept_mask | output | NUM_CORES | Cores that accept the command |
| err_flag | output | 1 | Command rejected |
| cmd_ignored | output | NUM_CORES | Start-up command ignored by a selected core |
| start_pulse | output | NUM_CORES | Core released to running |
| start_sel | output | 16 | Code-segment selector for released cores |
| start_base | output | 20 | Code-segment base for released cores |
| start_limit | output | 16 | Code-segment limit for released cores |
| start_ip | output | 16 | Instruction pointer for released cores |
| core_waiting | output | NUM_CORES | Core armed by initialise |
| core_running | output | NUM_CORES | Core released |

## Verification
A wrong match rule or shorthand decode shows up in `accept_mask` in the result cycle of the command that hits it. It appears as an extra or missing core, or as a false or missing error.

A wrong start-up state stays hidden until a later initialise or start-up command reaches that core. It then shows as a wrong `cmd_ignored` or `start_pulse` bit. It is also visible at once on `core_waiting`/`core_running`.

The random phase therefore keeps a state model of every core across many commands. It covers repeated initialise, start-up without initialise, and errored commands that must leave the state untouched.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_ARMED = 2'd1,
    CS_RUN = 2'd2
  } core_st_e;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_START  = 3'd6;

  localparam logic [3:0] FMT_FLAT    = 4'h0;
  localparam logic [3:0] FMT_CLUSTER = 4'hF;
  localparam logic [7:0] DEST_EVERY  = 8'hFF;

  localparam logic [1:0] SH_NONE  = 2'd0;
  localparam logic [1:0] SH_SELF  = 2'd1;
  localparam logic [1:0] SH_ALL   = 2'd2;
  localparam logic [1:0] SH_OTHER = 2'd3;
endpackage

// File: rtl/ipi_logical_match.sv
module ipi_logical_match
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 8,
  parameter int FMT_W     = 4
) (
  input  logic [ID_W-1:0]            dest,
  input  logic [ID_W*NUM_CORES-1:0]  ldr_flat,
  input  logic [FMT_W*NUM_CORES-1:0] fmt_flat,
  output logic [NUM_CORES-1:0]       hit,
  output logic                       bad_fmt
);
  localparam int NIB = ID_W / 2;

  logic [NUM_CORES-1:0] bad_core;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [ID_W-1:0]  lid;
    logic [FMT_W-1:0] fmt;
    assign lid = ldr_flat[i*ID_W +: ID_W];
    assign fmt = fmt_flat[i*FMT_W +: FMT_W];

    always_comb begin
      hit[i]      = 1'b0;
      bad_core[i] = 1'b0;
      if (dest == DEST_EVERY) begin
        hit[i] = 1'b1;
      end else if (fmt == FMT_CLUSTER) begin
        hit[i] = (dest[ID_W-1:NIB] == lid[ID_W-1:NIB]) &&
                 (|(dest[NIB-1:0] & lid[NIB-1:0]));
      end else if (fmt == FMT_FLAT) begin
        hit[i] = |(dest & lid);
      end else begin
        bad_core[i] = 1'b1;
      end
    end
  end

  assign bad_fmt = |bad_core;
endmodule

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 8,
  parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [1:0]           shorthand,
  input  logic                 logical,
  input  logic [ID_W-1:0]      dest,
  input  logic [SRC_W-1:0]     src,
  input  logic [NUM_CORES-1:0] log_hit,
  input  logic                 log_bad,
  output logic [NUM_CORES-1:0] mask,
  output logic                 err
);
  localparam logic [NUM_CORES-1:0] ALL_ONES = {NUM_CORES{1'b1}};
  localparam logic [NUM_CORES-1:0] ONE      = {{(NUM_CORES-1){1'b0}}, 1'b1};

  logic [NUM_CORES-1:0] src_bit;
  assign src_bit = ONE << src;

  always_comb begin
    mask = '0;
    err  = 1'b0;
    unique case (shorthand)
      SH_NONE: begin
        if (logical) begin
          mask = log_hit;
          err  = log_bad;
        end else if (int'(dest) < NUM_CORES) begin
          mask = ONE << dest;
        end else begin
          err = 1'b1;
        end
      end
      SH_SELF: begin
        if (logical) err = 1'b1;
        else         mask = src_bit;
      end
      SH_ALL:   mask = ALL_ONES;
      default:  mask = ALL_ONES & ~src_bit;
    endcase
    if (err) mask = '0;
  end

  always_comb begin
    if (shorthand == SH_OTHER) begin
      AST_OTHER_SKIPS_SRC: assert (!(|(mask & src_bit))); // R7
    end
  end
endmodule

// File: rtl/ipi_startup_fsm.sv
module ipi_startup_fsm
  import ipi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic is_init,
  input  logic is_start,
  output logic waiting,
  output logic running,
  output logic ignored,
  output logic started
);
  core_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= CS_IDLE;
      ignored <= 1'b0;
      started <= 1'b0;
    end else begin
      ignored <= 1'b0;
      started <= 1'b0;
      if (go && is_init) begin
        if (st_q == CS_IDLE) st_q <= CS_ARMED;
        else                 ignored <= 1'b1;
      end else if (go && is_start) begin
        if (st_q == CS_ARMED) begin
          st_q    <= CS_RUN;
          started <= 1'b1;
        end else begin
          ignored <= 1'b1;
        end
      end
    end
  end

  assign waiting = (st_q == CS_ARMED);
  assign running = (st_q == CS_RUN);

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R12
  AST_START_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(waiting) && started); // R12
  AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> $past(!running)); // R11
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int VEC_W     = 8,
  parameter int ID_W      = 8,
  parameter int FMT_W     = 4,
  parameter int SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [SRC_W-1:0]           cmd_src,
  input  logic [VEC_W-1:0]           cmd_vector,
  input  logic [2:0]                 cmd_dmode,
  input  logic                       cmd_logical,
  input  logic [1:0]                 cmd_short,
  input  logic [ID_W-1:0]            cmd_dest,
  input  logic [ID_W*NUM_CORES-1:0]  core_ldr,
  input  logic [FMT_W*NUM_CORES-1:0] core_dfr,
  output logic                       res_valid,
  output logic [NUM_CORES-1:0]       accept_mask,
  output logic                       err_flag,
  output logic [NUM_CORES-1:0]       cmd_ignored,
  output logic [NUM_CORES-1:0]       start_pulse,
  output logic [VEC_W+7:0]           start_sel,
  output logic [VEC_W+11:0]          start_base,
  output logic [15:0]                start_limit,
  output logic [15:0]                start_ip,
  output logic [NUM_CORES-1:0]       core_waiting,
  output logic [NUM_CORES-1:0]       core_running
);
  logic [NUM_CORES-1:0] log_hit;
  logic                 log_bad;
  logic [NUM_CORES-1:0] tgt_mask;
  logic                 tgt_err;
  logic                 mode_bad;
  logic                 cmd_err;
  logic                 is_init;
  logic                 is_start;
  logic [VEC_W-1:0]     vec_q;

  ipi_logical_match #(.NUM_CORES(NUM_CORES), .ID_W(ID_W), .FMT_W(FMT_W)) u_match (
    .dest(cmd_dest), .ldr_flat(core_ldr), .fmt_flat(core_dfr),
    .hit(log_hit), .bad_fmt(log_bad)
  );

  ipi_target_resolve #(.NUM_CORES(NUM_CORES), .ID_W(ID_W), .SRC_W(SRC_W)) u_resolve (
    .shorthand(cmd_short), .logical(cmd_logical), .dest(cmd_dest), .src(cmd_src),
    .log_hit(log_hit), .log_bad(log_bad), .mask(tgt_mask), .err(tgt_err)
  );

  always_comb begin
    unique case (cmd_dmode)
      DM_FIXED, DM_LOWEST, DM_INIT, DM_START: mode_bad = 1'b0;
      default:                                mode_bad = 1'b1;
    endcase
  end

  assign cmd_err  = mode_bad | tgt_err;
  assign is_init  = (cmd_dmode == DM_INIT);
  assign is_start = (cmd_dmode == DM_START);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_fsm
    ipi_startup_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .go(cmd_valid && !cmd_err && tgt_mask[i]),
      .is_init(is_init), .is_start(is_start),
      .waiting(core_waiting[i]), .running(core_running[i]),
      .ignored(cmd_ignored[i]), .started(start_pulse[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      accept_mask <= '0;
      err_flag    <= 1'b0;
      vec_q       <= '0;
    end else begin
      res_valid   <= cmd_valid;
      accept_mask <= (cmd_valid && !cmd_err) ? tgt_mask : '0;
      err_flag    <= cmd_valid && cmd_err;
      if (cmd_valid) vec_q <= cmd_vector;
    end
  end

  always_comb begin
    if (|start_pulse) begin
      start_sel   = {vec_q, 8'h00};
      start_base  = {vec_q, 12'h000};
      start_limit = 16'hFFFF;
    end else begin
      start_sel   = '0;
      start_base  = '0;
      start_limit = '0;
    end
    start_ip = '0;
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmd_valid)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (accept_mask == '0) && !err_flag && (start_pulse == '0)); // R2
  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (start_pulse == '0) && (cmd_ignored == '0) && $stable(core_running)); // R13
  AST_ACT_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_pulse | cmd_ignored) & ~accept_mask) == '0); // R11
endmodule

// File: tb/ipi_dest_resolver_tb.sv
module ipi_dest_resolver_tb;
  localparam int N = 4;
  localparam int SW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [SW-1:0] cmd_src = 0;
  logic [7:0] cmd_vector = 0;
  logic [2:0] cmd_dmode = 0;
  logic cmd_logical = 0;
  logic [1:0] cmd_short = 0;
  logic [7:0] cmd_dest = 0;
  logic [8*N-1:0] core_ldr = 0;
  logic [4*N-1:0] core_dfr = 0;
  logic res_valid, err_flag;
  logic [N-1:0] accept_mask, cmd_ignored, start_pulse, core_waiting, core_running;
  logic [15:0] start_sel, start_limit, start_ip;
  logic [19:0] start_base;

  int checks = 0;
  int fails = 0;
  int mst [N];

  always #10 clk = ~clk;

  ipi_dest_resolver #(.NUM_CORES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
    .cmd_vector(cmd_vector), .cmd_dmode(cmd_dmode), .cmd_logical(cmd_logical),
    .cmd_short(cmd_short), .cmd_dest(cmd_dest), .core_ldr(core_ldr), .core_dfr(core_dfr),
    .res_valid(res_valid), .accept_mask(accept_mask), .err_flag(err_flag),
    .cmd_ignored(cmd_ignored), .start_pulse(start_pulse), .start_sel(start_sel),
    .start_base(start_base), .start_limit(start_limit), .start_ip(start_ip),
    .core_waiting(core_waiting), .core_running(core_running)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N:0] model(int sh, int lg, int dst, int src, int dm);
    logic [N-1:0] m = '0;
    logic e = 0;
    if (dm == 2 || dm == 3 || dm == 4 || dm == 7) e = 1;
    case (sh)
      0: if (lg != 0) begin
           for (int i = 0; i < N; i++) begin
             logic [7:0] l = core_ldr[i*8 +: 8];
             logic [3:0] f = core_dfr[i*4 +: 4];
             logic [7:0] d = dst[7:0];
             if (d == 8'hFF) m[i] = 1;
             else if (f == 4'hF) m[i] = (d[7:4] == l[7:4]) && ((d[3:0] & l[3:0]) != 0);
             else if (f == 4'h0) m[i] = (d & l) != 0;
             else e = 1;
           end
         end else if (dst < N) m[dst] = 1;
         else e = 1;
      1: if (lg != 0) e = 1; else m[src] = 1;
      2: m = '1;
      default: begin m = '1; m[src] = 0; end
    endcase
    if (e) m = '0;
    return {e, m};
  endfunction

  task automatic send(string tag, int sh, int lg, int dst, int src, int dm, int vec);
    logic [N:0] r;
    logic [N-1:0] ew, es, ewait, erun;
    r = model(sh, lg, dst, src, dm);
    ew = '0; es = '0;
    if (!r[N]) begin
      for (int i = 0; i < N; i++) begin
        if (r[i] && dm == 5) begin
          if (mst[i] == 0) mst[i] = 1; else ew[i] = 1;
        end else if (r[i] && dm == 6) begin
          if (mst[i] == 1) begin mst[i] = 2; es[i] = 1; end else ew[i] = 1;
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      ewait[i] = (mst[i] == 1);
      erun[i]  = (mst[i] == 2);
    end
    @(negedge clk);
    cmd_valid = 1; cmd_short = sh[1:0]; cmd_logical = lg[0]; cmd_dest = dst[7:0];
    cmd_src = src[SW-1:0]; cmd_dmode = dm[2:0]; cmd_vector = vec[7:0];
    @(negedge clk);
    cmd_valid = 0;
    chk("R2 res_valid", res_valid, 1);
    chk({tag, " mask"}, accept_mask, r[N-1:0]);
    chk({tag, " err"}, err_flag, r[N]);
    chk("R11 ignored", cmd_ignored, ew);
    chk("R12 start_pulse", start_pulse, es);
    chk("R12 sel", start_sel, (es != 0) ? {vec[7:0], 8'h00} : 16'h0);
    chk("R12 base", start_base, (es != 0) ? {vec[7:0], 12'h000} : 20'h0);
    chk("R12 limit", start_limit, (es != 0) ? 16'hFFFF : 16'h0);
    chk("R12 ip", start_ip, 0);
    chk("R11 waiting", core_waiting, ewait);
    chk("R12 running", core_running, erun);
    @(negedge clk);
    chk("R2 drop", {res_valid, accept_mask, err_flag}, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) mst[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 waiting", core_waiting, 0);
    chk("R1 running", core_running, 0);
    chk("R1 outputs", {res_valid, accept_mask, err_flag, start_pulse}, 0);
    rst_n = 1;
    core_ldr = {8'h88, 8'h04, 8'h02, 8'h01};
    core_dfr = {4'h0, 4'h0, 4'h0, 4'h0};
    send("R4 flat", 0, 1, 8'h03, 0, 0, 8'h30);
    send("R4 flat miss", 0, 1, 8'h70, 0, 1, 8'h31);
    core_dfr = {4'h3, 4'h3, 4'h3, 4'h3};
    send("R3 broadcast", 0, 1, 8'hFF, 2, 0, 8'h32);
    core_ldr = {8'h13, 8'h21, 8'h12, 8'h11};
    core_dfr = {4'hF, 4'hF, 4'hF, 4'hF};
    send("R5 cluster", 0, 1, 8'h13, 0, 0, 8'h33);
    send("R5 cluster other", 0, 1, 8'h21, 0, 0, 8'h34);
    core_dfr = {4'hF, 4'h5, 4'hF, 4'hF};
    send("R6 bad format", 0, 1, 8'h13, 0, 0, 8'h35);
    send("R8 physical", 0, 0, 2, 0, 0, 8'h36);
    send("R8 out of range", 0, 0, 4, 0, 0, 8'h37);
    send("R9 self logical", 1, 1, 0, 1, 0, 8'h38);
    send("R7 self", 1, 0, 0, 1, 0, 8'h39);
    send("R7 all", 2, 1, 0, 1, 0, 8'h3A);
    send("R7 others", 3, 0, 0, 1, 0, 8'h3B);
    send("R10 mode4", 2, 0, 0, 1, 4, 8'h3C);
    send("R13 err init", 0, 0, 7, 0, 5, 8'h3D);
    send("R11 init", 0, 0, 2, 0, 5, 8'h3E);
    send("R11 init again", 0, 0, 2, 0, 5, 8'h3F);
    send("R12 start", 0, 0, 2, 1, 6, 8'h9A);
    send("R12 start unarmed", 0, 0, 0, 1, 6, 8'h9B);
    send("R11 init running", 0, 0, 2, 0, 5, 8'h40);
    send("R10 mode7", 0, 0, 1, 0, 7, 8'h41);
    for (int k = 0; k < 1500; k++) begin
      if (k % 300 == 0) begin
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < N; i++) mst[i] = 0;
        chk("R1 after reset", {core_waiting, core_running}, 0);
      end
      for (int i = 0; i < N; i++) begin
        int f;
        core_ldr[i*8 +: 8] = $urandom() % 256;
        f = $urandom() % 10;
        core_dfr[i*4 +: 4] = (f < 5) ? 4'h0 : (f < 9) ? 4'hF : 4'h6;
      end
      send("R7 random", $urandom() % 4, $urandom() % 2,
           ($urandom() % 4 == 0) ? 8'hFF : $urandom() % 256 % ((($urandom() % 2) == 0) ? 6 : 256),
           $urandom() % N, $urandom() % 8, $urandom() % 256);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule